// File: doc/BRIEF.md
# Shadow Stack Instruction Decoder

This block classifies one instruction word, either a full 32-bit word or a compressed 16-bit word, as a shadow-stack operation or as an ordinary may-be-operation. The shadow-stack forms are carved out of code points that are otherwise reserved as may-be-operations. Those forms are a push of a link register, a pop that compares the popped value against a link register, and a read of the shadow-stack pointer. Whether a carved-out code point acts as a shadow-stack operation is settled at run time by an effective enable. The enable is built from the current privilege level, the virtualization flag and three environment-configuration enable bits, one each for the machine, hypervisor and supervisor levels.

The block produces an operation class, the register index that is pushed or compared, the destination register index and an illegal flag for compressed words that are reserved. All results, including the effective enable, are registered once, so they appear one clock after the inputs. Memory traffic, the pointer register itself and exception delivery are left to neighbouring logic.

Top module: `ssdec_top`

## Requirements
- R1: The effective enable `ss_en_o` is 0 whenever the privilege input is machine (2'b11), whenever `menv_sse_i` is 0, or whenever `smode_present_i` is 0. Privilege encodings are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R2: Outside machine mode, with `menv_sse_i` and `smode_present_i` set, the enable also needs `henv_sse_i` when `virt_i` is 1 and `senv_sse_i` when the privilege is user. Otherwise it is 1.
- R3: In a 32-bit one-source may-be-operation word, the fields are: opcode [6:0]=1110011, [14:12]=100, [31]=1, [29:28]=00, [25:22]=0111, with slot number {[30],[27:26],[21:20]}. In slot 28, a word with rd [11:7]=0 and rs1 [19:15] equal to 1 or 5 decodes, when enabled, as pop-and-check (op 4) with `src_idx_o`=rs1 and `dst_idx_o`=0.
- R4: In slot 28 with rd≠0 and rs1=0, the word decodes, when enabled, as a pointer read (op 5) with `dst_idx_o`=rd and `src_idx_o`=0.
- R5: In a 32-bit two-source may-be-operation word, the fields are: the same opcode, [14:12], [31] and [29:28] as in R3, [25]=1, with slot {[30],[27:26]}. In slot 7, a word with rd=0, rs1=0 and rs2 [24:20] equal to 1 or 5 decodes, when enabled, as a push (op 3) with `src_idx_o`=rs2 and `dst_idx_o`=0.
- R6: A compressed word is one with [1:0]≠11. A compressed may-be-operation has [15:13]=011, [12]=0, [6:2]=0, [1:0]=01 and a register field [11:7] that is odd and below 16. When enabled, field value 1 decodes as a push of register 1, and field value 5 as a pop-and-check of register 5.
- R7: When the enable is 0, every push, pop and read form gives the plain result for its word: op 1 with `dst_idx_o`=rd for 32-bit words, and op 2 with both indices 0 for compressed words.
- R8: Every other 32-bit may-be-operation word, in any slot and with any field combination not listed in R3 to R5, gives op 1 (write zero to rd) with `dst_idx_o`=rd and `src_idx_o`=0. Every other compressed may-be-operation gives op 2 (no effect) with both indices 0.
- R9: A compressed word with [15:13]=011, [12]=0, [6:2]=0 and [1:0]=01 whose register field is not odd-and-below-16 raises `illegal_o` with op 0. No other word raises `illegal_o`.
- R10: Any word that is not a may-be-operation gives op 0 with both indices 0. After reset, and while reset is held, all outputs are 0. Results appear on the outputs one clock after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 32 | Instruction word; a compressed word sits in [15:0] |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization active |
| menv_sse_i | input | 1 | Machine-level shadow-stack enable bit |
| henv_sse_i | input | 1 | Hypervisor-level shadow-stack enable bit |
| senv_sse_i | input | 1 | Supervisor-level shadow-stack enable bit |
| smode_present_i | input | 1 | Supervisor mode is implemented |
| ss_en_o | output | 1 | Registered effective shadow-stack enable |
| op_o | output | 3 | 0 none, 1 plain (rd←0), 2 compressed no-op, 3 push, 4 pop-and-check, 5 pointer read |
| src_idx_o | output | 5 | Register pushed or compared |
| dst_idx_o | output | 5 | Destination register |
| illegal_o | output | 1 | Reserved compressed encoding |

## Verification
The bench aims at the edges of the carved-out regions. These include slot 28 with rd=0 and rs1=2, with rd≠0 and rs1=1, and slot 7 with rs2=2 or with rs1≠0. A decoder with loose field matching would claim these words as shadow-stack operations instead of plain ones. It also drives each enable term false in turn: machine mode, a missing hypervisor bit under virtualization, a missing supervisor bit in user mode, and an absent supervisor mode. A wrong enable equation would leave a push or pop active in one of these cases. Reserved compressed register fields (0, 2, 8) are checked for the illegal flag, and a compressed word with a nonzero immediate is checked to stay unclaimed.

// File: rtl/ssdec_pkg.sv
package ssdec_pkg;

    localparam int unsigned ILEN      = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned OP_W      = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE    = 3'd0,
        OP_MOP_ZER = 3'd1,
        OP_MOP_NOP = 3'd2,
        OP_PUSH    = 3'd3,
        OP_POPCHK  = 3'd4,
        OP_RDPTR   = 3'd5
    } ss_op_e;

    localparam logic [1:0] PRIV_USER  = 2'b00;
    localparam logic [1:0] PRIV_SUPER = 2'b01;
    localparam logic [1:0] PRIV_MACH  = 2'b11;

    typedef struct packed {
        logic                 en;
        ss_op_e               op;
        logic [REG_IDX_W-1:0] src;
        logic [REG_IDX_W-1:0] dst;
        logic                 ill;
    } dec_res_t;

endpackage

// File: rtl/ssdec_enable.sv
module ssdec_enable
    import ssdec_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic       menv_sse_i,
    input  logic       henv_sse_i,
    input  logic       senv_sse_i,
    input  logic       smode_present_i,
    output logic       en_o
);
    logic not_mach;
    logic virt_ok;
    logic user_ok;

    always_comb begin
        not_mach = (priv_i != PRIV_MACH);
        virt_ok  = !virt_i || henv_sse_i;
        user_ok  = (priv_i != PRIV_USER) || senv_sse_i;
        en_o     = not_mach && menv_sse_i && smode_present_i && virt_ok && user_ok;
    end
endmodule

// File: rtl/ssdec_wide.sv
module ssdec_wide
    import ssdec_pkg::*;
#(
    parameter int unsigned R_SLOT  = 28,
    parameter int unsigned RR_SLOT = 7,
    parameter int unsigned LINK_A  = 1,
    parameter int unsigned LINK_B  = 5
) (
    input  logic [ILEN-1:0]      insn_i,
    input  logic                 en_i,
    output logic                 hit_o,
    output ss_op_e               op_o,
    output logic [REG_IDX_W-1:0] src_o,
    output logic [REG_IDX_W-1:0] dst_o
);
    localparam logic [6:0] OPC_SYS = 7'b1110011;
    localparam logic [4:0] R_SLOT_V  = R_SLOT[4:0];
    localparam logic [2:0] RR_SLOT_V = RR_SLOT[2:0];
    localparam logic [REG_IDX_W-1:0] LA = LINK_A[REG_IDX_W-1:0];
    localparam logic [REG_IDX_W-1:0] LB = LINK_B[REG_IDX_W-1:0];

    logic                 base;
    logic                 is_r;
    logic                 is_rr;
    logic [4:0]           slot_r;
    logic [2:0]           slot_rr;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rs1;
    logic [REG_IDX_W-1:0] rs2;

    always_comb begin
        rd      = insn_i[11:7];
        rs1     = insn_i[19:15];
        rs2     = insn_i[24:20];
        base    = (insn_i[6:0] == OPC_SYS) && (insn_i[14:12] == 3'b100) &&
                  insn_i[31] && (insn_i[29:28] == 2'b00);
        is_r    = base && (insn_i[25:22] == 4'b0111);
        is_rr   = base && insn_i[25];
        slot_r  = {insn_i[30], insn_i[27:26], insn_i[21:20]};
        slot_rr = {insn_i[30], insn_i[27:26]};

        hit_o = is_r || is_rr;
        op_o  = OP_NONE;
        src_o = '0;
        dst_o = '0;
        if (hit_o) begin
            op_o  = OP_MOP_ZER;
            dst_o = rd;
        end
        if (en_i && is_r && (slot_r == R_SLOT_V)) begin
            if ((rd == '0) && ((rs1 == LA) || (rs1 == LB))) begin
                op_o  = OP_POPCHK;
                src_o = rs1;
            end else if ((rd != '0) && (rs1 == '0)) begin
                op_o  = OP_RDPTR;
            end
        end
        if (en_i && is_rr && (slot_rr == RR_SLOT_V) && (rd == '0) && (rs1 == '0) &&
            ((rs2 == LA) || (rs2 == LB))) begin
            op_o  = OP_PUSH;
            src_o = rs2;
        end
    end
endmodule

// File: rtl/ssdec_comp.sv
module ssdec_comp
    import ssdec_pkg::*;
#(
    parameter int unsigned LINK_A = 1,
    parameter int unsigned LINK_B = 5
) (
    input  logic [15:0]          insn_i,
    input  logic                 en_i,
    output ss_op_e               op_o,
    output logic [REG_IDX_W-1:0] src_o,
    output logic                 ill_o
);
    localparam logic [REG_IDX_W-1:0] LA = LINK_A[REG_IDX_W-1:0];
    localparam logic [REG_IDX_W-1:0] LB = LINK_B[REG_IDX_W-1:0];

    logic                 zero_imm_lui;
    logic                 mop_field;
    logic [REG_IDX_W-1:0] fld;

    always_comb begin
        fld          = insn_i[11:7];
        zero_imm_lui = (insn_i[15:13] == 3'b011) && !insn_i[12] &&
                       (insn_i[6:2] == 5'd0) && (insn_i[1:0] == 2'b01);
        mop_field    = fld[0] && !fld[4];
        op_o  = OP_NONE;
        src_o = '0;
        ill_o = 1'b0;
        if (zero_imm_lui) begin
            if (!mop_field) begin
                ill_o = 1'b1;
            end else if (en_i && (fld == LA)) begin
                op_o  = OP_PUSH;
                src_o = LA;
            end else if (en_i && (fld == LB)) begin
                op_o  = OP_POPCHK;
                src_o = LB;
            end else begin
                op_o  = OP_MOP_NOP;
            end
        end
    end
endmodule

// File: rtl/ssdec_top.sv
module ssdec_top
    import ssdec_pkg::*;
#(
    parameter bit          HAS_COMPRESSED = 1'b1,
    parameter int unsigned LINK_A         = 1,
    parameter int unsigned LINK_B         = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ILEN-1:0]      insn_i,
    input  logic [1:0]           priv_i,
    input  logic                 virt_i,
    input  logic                 menv_sse_i,
    input  logic                 henv_sse_i,
    input  logic                 senv_sse_i,
    input  logic                 smode_present_i,
    output logic                 ss_en_o,
    output logic [OP_W-1:0]      op_o,
    output logic [REG_IDX_W-1:0] src_idx_o,
    output logic [REG_IDX_W-1:0] dst_idx_o,
    output logic                 illegal_o
);
    logic                 en_w;
    logic                 w_hit;
    ss_op_e               w_op;
    logic [REG_IDX_W-1:0] w_src;
    logic [REG_IDX_W-1:0] w_dst;
    ss_op_e               c_op;
    logic [REG_IDX_W-1:0] c_src;
    logic                 c_ill;
    logic                 is_comp;
    dec_res_t             res_d;
    dec_res_t             res_q;

    ssdec_enable u_en (
        .priv_i          (priv_i),
        .virt_i          (virt_i),
        .menv_sse_i      (menv_sse_i),
        .henv_sse_i      (henv_sse_i),
        .senv_sse_i      (senv_sse_i),
        .smode_present_i (smode_present_i),
        .en_o            (en_w)
    );

    ssdec_wide #(
        .LINK_A (LINK_A),
        .LINK_B (LINK_B)
    ) u_wide (
        .insn_i (insn_i),
        .en_i   (en_w),
        .hit_o  (w_hit),
        .op_o   (w_op),
        .src_o  (w_src),
        .dst_o  (w_dst)
    );

    generate
        if (HAS_COMPRESSED) begin : g_comp
            ssdec_comp #(
                .LINK_A (LINK_A),
                .LINK_B (LINK_B)
            ) u_comp (
                .insn_i (insn_i[15:0]),
                .en_i   (en_w),
                .op_o   (c_op),
                .src_o  (c_src),
                .ill_o  (c_ill)
            );
        end else begin : g_nocomp
            assign c_op  = OP_NONE;
            assign c_src = '0;
            assign c_ill = 1'b0;
        end
    endgenerate

    always_comb begin
        is_comp   = (insn_i[1:0] != 2'b11);
        res_d     = '0;
        res_d.en  = en_w;
        if (is_comp) begin
            res_d.op  = c_op;
            res_d.src = c_src;
            res_d.ill = c_ill;
        end else if (w_hit) begin
            res_d.op  = w_op;
            res_d.src = w_src;
            res_d.dst = w_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign ss_en_o   = res_q.en;
    assign op_o      = res_q.op;
    assign src_idx_o = res_q.src;
    assign dst_idx_o = res_q.dst;
    assign illegal_o = res_q.ill;
endmodule

// File: rtl/ssdec_chk.sv
module ssdec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] priv_i,
    input logic       menv_sse_i,
    input logic       smode_present_i,
    input logic       ss_en_o,
    input logic [2:0] op_o,
    input logic [4:0] src_idx_o,
    input logic [4:0] dst_idx_o,
    input logic       illegal_o
);
    p_mach_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == 2'b11) |=> !ss_en_o);

    p_menv_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!menv_sse_i || !smode_present_i) |=> !ss_en_o);

    p_ss_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_o == 3'd3) || (op_o == 3'd4) || (op_o == 3'd5)) |-> ss_en_o);

    p_link_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_o == 3'd3) || (op_o == 3'd4)) |-> (((src_idx_o == 5'd1) || (src_idx_o == 5'd5)) && (dst_idx_o == 5'd0)));

    p_rdptr_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 3'd5) |-> ((dst_idx_o != 5'd0) && (src_idx_o == 5'd0)));

    p_ill_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ((op_o == 3'd0) && (src_idx_o == 5'd0) && (dst_idx_o == 5'd0)));

    p_op_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o <= 3'd5));
endmodule

bind ssdec_top ssdec_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .priv_i          (priv_i),
    .menv_sse_i      (menv_sse_i),
    .smode_present_i (smode_present_i),
    .ss_en_o         (ss_en_o),
    .op_o            (op_o),
    .src_idx_o       (src_idx_o),
    .dst_idx_o       (dst_idx_o),
    .illegal_o       (illegal_o)
);

// File: tb/tb_ssdec_top.sv
module tb_ssdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0;
    logic [1:0]  priv_i = 2'b00;
    logic        virt_i = 1'b0;
    logic        menv_sse_i = 1'b0;
    logic        henv_sse_i = 1'b0;
    logic        senv_sse_i = 1'b0;
    logic        smode_present_i = 1'b0;
    logic        ss_en_o;
    logic [2:0]  op_o;
    logic [4:0]  src_idx_o;
    logic [4:0]  dst_idx_o;
    logic        illegal_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ssdec_top dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .insn_i          (insn_i),
        .priv_i          (priv_i),
        .virt_i          (virt_i),
        .menv_sse_i      (menv_sse_i),
        .henv_sse_i      (henv_sse_i),
        .senv_sse_i      (senv_sse_i),
        .smode_present_i (smode_present_i),
        .ss_en_o         (ss_en_o),
        .op_o            (op_o),
        .src_idx_o       (src_idx_o),
        .dst_idx_o       (dst_idx_o),
        .illegal_o       (illegal_o)
    );

    typedef struct packed {
        logic [31:0] insn;
        logic [1:0]  priv;
        logic        virt;
        logic        m;
        logic        h;
        logic        s;
        logic        sm;
        logic        en;
        logic [2:0]  op;
        logic [4:0]  src;
        logic [4:0]  dst;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'hCDC0C073, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 5'd1, 5'd0, 1'b0, 8'd3},
        '{32'hCDC2C073, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 5'd5, 5'd0, 1'b0, 8'd3},
        '{32'hCDC043F3, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 5'd0, 5'd7, 1'b0, 8'd4},
        '{32'hCDC14073, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 5'd0, 5'd0, 1'b0, 8'd8},
        '{32'hCDC0C1F3, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 5'd0, 5'd3, 1'b0, 8'd8},
        '{32'hCE104073, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 5'd1, 5'd0, 1'b0, 8'd5},
        '{32'hCE504073, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 5'd5, 5'd0, 1'b0, 8'd2},
        '{32'hCE204073, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 5'd0, 5'd0, 1'b0, 8'd8},
        '{32'hCE10C073, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 5'd0, 5'd0, 1'b0, 8'd8},
        '{32'h81C04273, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 5'd0, 5'd4, 1'b0, 8'd8},
        '{32'h00500093, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 5'd0, 5'd0, 1'b0, 8'd10},
        '{32'h00006081, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 5'd1, 5'd0, 1'b0, 8'd6},
        '{32'h00006281, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 5'd5, 5'd0, 1'b0, 8'd6},
        '{32'h00006181, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 5'd0, 5'd0, 1'b0, 8'd8},
        '{32'h00006001, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 5'd0, 5'd0, 1'b1, 8'd9},
        '{32'h00006101, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 5'd0, 5'd0, 1'b1, 8'd9},
        '{32'h00006401, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 5'd0, 5'd0, 1'b1, 8'd9},
        '{32'h00006085, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 5'd0, 5'd0, 1'b0, 8'd9},
        '{32'hCDC0C073, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 5'd0, 5'd0, 1'b0, 8'd1},
        '{32'hCDC043F3, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 5'd0, 5'd7, 1'b0, 8'd7},
        '{32'hCE104073, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 5'd0, 5'd0, 1'b0, 8'd2},
        '{32'h00006081, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 5'd0, 5'd0, 1'b0, 8'd7},
        '{32'h00006281, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 5'd0, 5'd0, 1'b0, 8'd1},
        '{32'hCDC2C073, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 5'd5, 5'd0, 1'b0, 8'd2}
    };

    task automatic check_out(input logic en, input logic [2:0] op, input logic [4:0] src,
                             input logic [4:0] dst, input logic ill, input int req, input string tag);
        checks++;
        if ((ss_en_o !== en) || (op_o !== op) || (src_idx_o !== src) ||
            (dst_idx_o !== dst) || (illegal_o !== ill)) begin
            errors++;
            $display("FAIL R%0d %s: got en=%0b op=%0d src=%0d dst=%0d ill=%0b, expected en=%0b op=%0d src=%0d dst=%0d ill=%0b",
                     req, tag, ss_en_o, op_o, src_idx_o, dst_idx_o, illegal_o, en, op, src, dst, ill);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        insn_i = v.insn; priv_i = v.priv; virt_i = v.virt;
        menv_sse_i = v.m; henv_sse_i = v.h; senv_sse_i = v.s; smode_present_i = v.sm;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R10: outputs zero while reset is held, even with a decodable word and enable set
        insn_i = 32'hCE104073; priv_i = 2'b01; menv_sse_i = 1'b1; smode_present_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_out(1'b0, 3'd0, 5'd0, 5'd0, 1'b0, 10, "r10_reset_state");
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check_out(VECS[i].en, VECS[i].op, VECS[i].src, VECS[i].dst, VECS[i].ill,
                      int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R10: one-cycle latency, output holds until the next edge
        @(negedge clk);
        insn_i = 32'h00006001;
        #1;
        check_out(1'b1, 3'd4, 5'd5, 5'd0, 1'b0, 10, "r10_hold_before_edge");
        @(posedge clk);
        #1;
        check_out(1'b1, 3'd0, 5'd0, 5'd0, 1'b1, 9, "r9_after_edge");

        // R2: supervisor mode ignores the supervisor-level bit
        @(negedge clk);
        insn_i = 32'hCE504073; priv_i = 2'b01; virt_i = 1'b0; senv_sse_i = 1'b0;
        @(posedge clk);
        #1;
        check_out(1'b1, 3'd3, 5'd5, 5'd0, 1'b0, 2, "r2_super_no_senv");

        // R10: reset asserted mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_out(1'b0, 3'd0, 5'd0, 5'd0, 1'b0, 10, "r10_mid_reset");
        done = 1'b1;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
        end
    end

    initial begin
        wait (done || ($time > 10000));
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule